// File: doc/BRIEF.md
# Low-Power SDRAM Power-Up Sequencer

This block sits on the controller side of a low-power SDRAM interface. It steps the memory through its mandatory start-up command order before any normal traffic may reach it. From reset it holds the clock-enable and data-mask pins high and issues only idle commands. It waits for a power-good indication, then lets a long settling interval pass. After that it issues a precharge of every bank, two auto-refresh cycles, and finally writes the standard mode register and the extended mode register. Once the last settling gap has elapsed, it raises a ready flag that stays high until the next reset.

Every minimum spacing is a parameter counted in clock cycles. The settling wait, the precharge recovery, the refresh recovery and the mode-register recovery all share one down-counter. The counter loads the parameter minus one, so the number of idle cycles between two commands equals the parameter exactly.

The CAS-latency field of the configured mode word is validated when its write slot comes up. An illegal code is never sent to the memory. The sequencer parks in an error state, keeps issuing idle commands, and never reports ready.

States, in order: S_WAIT_PWR (idle until power-good), S_STABLE (settling wait), S_PREA (precharge all), S_GAP_RP, S_REF1, S_GAP_RFC1, S_REF2, S_GAP_RFC2, S_MRS (standard mode write or CAS-latency rejection), S_GAP_MRD1, S_EMRS (extended mode write), S_GAP_MRD2, S_DONE (ready, terminal), S_ERR (rejected configuration, terminal). Transitions are as follows:
- S_WAIT_PWR goes to S_STABLE when pwr_stable is high.
- Each command state goes to its gap state after one cycle.
- Each gap state or wait state moves on when its count runs out.
- S_MRS goes to S_GAP_MRD1 for a legal latency code and to S_ERR otherwise.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: cke and dqm are high from reset onward, in every cycle of the sequence and after it.
- R2: The idle command is cs_n=0, ras_n=1, cas_n=1, we_n=1. While pwr_stable has never been seen high since reset, only idle commands are issued.
- R3: After pwr_stable is sampled high, exactly T_STABLE idle cycles pass and then PRECHARGE ALL is issued. PRECHARGE ALL is cs_n=0, ras_n=0, cas_n=1, we_n=0 with addr[10]=1.
- R4: Exactly T_RP idle cycles after the precharge, the first AUTO REFRESH is issued. AUTO REFRESH is cs_n=0, ras_n=0, cas_n=0, we_n=1.
- R5: The second AUTO REFRESH follows the first after exactly T_RFC idle cycles. T_RFC idle cycles then follow the second.
- R6: The mode-register write is cs_n=0, ras_n=0, cas_n=0, we_n=0. The standard register is written first, with ba=00 and addr equal to mr_cfg passed through unchanged (burst length addr[2:0], burst type addr[3], CAS latency addr[6:4], write-burst mode addr[9]). After exactly T_MRD idle cycles, the extended register is written with ba=10 and addr=emr_cfg.
- R7: Only CAS-latency codes mr_cfg[6:4] = 010 and 011 are legal. With any other code, no mode-register write is issued: the slot carries an idle command. cfg_err rises in the next cycle, so T_RFC+1 idle cycles after the second refresh. Afterwards only idle commands follow and init_done stays low.
- R8: init_done rises in the first cycle after the T_MRD idle cycles that follow the extended-register write. It stays high until reset, and only idle commands are issued while it is high.
- R9: A reset applied at any point forces idle commands and init_done low. On release, the complete sequence restarts from waiting for pwr_stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_stable | input | 1 | Supplies and clock are stable |
| mr_cfg | input | ADDR_W | Value to write into the standard mode register |
| emr_cfg | input | ADDR_W | Value to write into the extended mode register |
| cke | output | 1 | SDRAM clock enable |
| dqm | output | 1 | SDRAM data mask |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Device ready for normal operation |
| cfg_err | output | 1 | Illegal CAS-latency code rejected |

## Verification
The bench counts the idle cycles between every pair of commands and compares each count with its parameter. A timer loaded without the minus-one adjustment, or a gap state left one cycle early, shows up as a gap that is off by one. It resets the block in the middle of the refresh phase. A sequencer that resumes where it stopped, rather than waiting for power-good again, produces a precharge at the wrong distance or a missing command. Two illegal latency codes are configured in turn. A design that sends the write anyway, reports ready, or raises the error flag one cycle off is caught at the pins.

// File: rtl/sdram_pwrup_pkg.sv
package sdram_pwrup_pkg;

    typedef enum logic [3:0] {
        S_WAIT_PWR,
        S_STABLE,
        S_PREA,
        S_GAP_RP,
        S_REF1,
        S_GAP_RFC1,
        S_REF2,
        S_GAP_RFC2,
        S_MRS,
        S_GAP_MRD1,
        S_EMRS,
        S_GAP_MRD2,
        S_DONE,
        S_ERR
    } seq_state_t;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PREA,
        CMD_REF,
        CMD_MRS
    } sdram_cmd_t;

    localparam logic [2:0] CL_CODE_2 = 3'b010;
    localparam logic [2:0] CL_CODE_3 = 3'b011;
    localparam int         CL_LSB    = 4;
    localparam int         AP_BIT    = 10;
    localparam logic [1:0] BA_STD_MR = 2'b00;
    localparam logic [1:0] BA_EXT_MR = 2'b10;

    function automatic logic cl_legal(input logic [2:0] code);
        return (code == CL_CODE_2) || (code == CL_CODE_3);
    endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    AST_TIMER_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5

    AST_TIMER_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val))); // R4

endmodule

// File: rtl/sdram_cmd_encoder.sv
module sdram_cmd_encoder
    import sdram_pwrup_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  sdram_cmd_t        cmd,
    input  logic [ADDR_W-1:0] mrs_addr,
    input  logic [BA_W-1:0]   mrs_ba,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba
);

    always_comb begin
        cs_n  = 1'b0;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        addr  = '0;
        ba    = '0;
        unique case (cmd)
            CMD_NOP: begin
            end
            CMD_PREA: begin
                ras_n        = 1'b0;
                we_n         = 1'b0;
                addr[AP_BIT] = 1'b1;
            end
            CMD_REF: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            CMD_MRS: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                addr  = mrs_addr;
                ba    = mrs_ba;
            end
        endcase
    end

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_pwrup_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int BA_W     = 2,
    parameter int T_STABLE = 20000,
    parameter int T_RP     = 3,
    parameter int T_RFC    = 10,
    parameter int T_MRD    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_stable,
    input  logic [ADDR_W-1:0] mr_cfg,
    input  logic [ADDR_W-1:0] emr_cfg,
    output logic              cke,
    output logic              dqm,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done,
    output logic              cfg_err
);

    localparam int MAX_A   = (T_STABLE > T_RP)  ? T_STABLE : T_RP;
    localparam int MAX_B   = (T_RFC > T_MRD)    ? T_RFC    : T_MRD;
    localparam int MAX_GAP = (MAX_A > MAX_B)    ? MAX_A    : MAX_B;
    localparam int CNT_W   = $clog2(MAX_GAP + 1);

    localparam logic [CNT_W-1:0] LD_STABLE = CNT_W'(T_STABLE - 1);
    localparam logic [CNT_W-1:0] LD_RP     = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] LD_RFC    = CNT_W'(T_RFC - 1);
    localparam logic [CNT_W-1:0] LD_MRD    = CNT_W'(T_MRD - 1);

    seq_state_t       state_q, state_d;
    sdram_cmd_t       cmd;
    logic [ADDR_W-1:0] mrs_addr;
    logic [BA_W-1:0]   mrs_ba;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic              cl_ok;

    assign cl_ok = cl_legal(mr_cfg[CL_LSB+2:CL_LSB]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_WAIT_PWR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_WAIT_PWR: if (pwr_stable)  state_d = S_STABLE;
            S_STABLE:   if (tmr_expired) state_d = S_PREA;
            S_PREA:                      state_d = S_GAP_RP;
            S_GAP_RP:   if (tmr_expired) state_d = S_REF1;
            S_REF1:                      state_d = S_GAP_RFC1;
            S_GAP_RFC1: if (tmr_expired) state_d = S_REF2;
            S_REF2:                      state_d = S_GAP_RFC2;
            S_GAP_RFC2: if (tmr_expired) state_d = S_MRS;
            S_MRS:                       state_d = cl_ok ? S_GAP_MRD1 : S_ERR;
            S_GAP_MRD1: if (tmr_expired) state_d = S_EMRS;
            S_EMRS:                      state_d = S_GAP_MRD2;
            S_GAP_MRD2: if (tmr_expired) state_d = S_DONE;
            S_DONE:                      state_d = S_DONE;
            S_ERR:                       state_d = S_ERR;
            default:                     state_d = S_WAIT_PWR;
        endcase
    end

    always_comb begin
        cmd       = CMD_NOP;
        mrs_addr  = '0;
        mrs_ba    = '0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        init_done = 1'b0;
        cfg_err   = 1'b0;
        unique case (state_q)
            S_WAIT_PWR: begin
                tmr_load = pwr_stable;
                tmr_val  = LD_STABLE;
            end
            S_PREA: begin
                cmd      = CMD_PREA;
                tmr_load = 1'b1;
                tmr_val  = LD_RP;
            end
            S_REF1, S_REF2: begin
                cmd      = CMD_REF;
                tmr_load = 1'b1;
                tmr_val  = LD_RFC;
            end
            S_MRS: begin
                if (cl_ok) begin
                    cmd      = CMD_MRS;
                    mrs_addr = mr_cfg;
                    mrs_ba   = BA_W'(BA_STD_MR);
                    tmr_load = 1'b1;
                    tmr_val  = LD_MRD;
                end
            end
            S_EMRS: begin
                cmd      = CMD_MRS;
                mrs_addr = emr_cfg;
                mrs_ba   = BA_W'(BA_EXT_MR);
                tmr_load = 1'b1;
                tmr_val  = LD_MRD;
            end
            S_DONE:  init_done = 1'b1;
            S_ERR:   cfg_err   = 1'b1;
            S_STABLE, S_GAP_RP, S_GAP_RFC1, S_GAP_RFC2,
            S_GAP_MRD1, S_GAP_MRD2: begin
            end
            default: begin
            end
        endcase
    end

    assign cke = 1'b1;
    assign dqm = 1'b1;

    sdram_gap_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sdram_cmd_encoder #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_enc (
        .cmd      (cmd),
        .mrs_addr (mrs_addr),
        .mrs_ba   (mrs_ba),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .addr     (addr),
        .ba       (ba)
    );

    AST_CMD_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n) |=> (ras_n && cas_n && we_n)); // R4

    AST_STD_MR_CL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && !cas_n && !we_n && ba == BA_W'(BA_STD_MR))
            |-> cl_legal(addr[CL_LSB+2:CL_LSB])); // R7

    AST_ERR_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!init_done && ras_n && cas_n && we_n)); // R7

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done); // R8

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (!cs_n && ras_n && cas_n && we_n)); // R8

endmodule

// File: tb/sdram_pwrup_seq_bench.sv
module sdram_pwrup_seq_bench;

    localparam int ADDR_W   = 13;
    localparam int BA_W     = 2;
    localparam int T_STABLE = 40;
    localparam int T_RP     = 3;
    localparam int T_RFC    = 7;
    localparam int T_MRD    = 2;

    typedef struct {
        int               code;
        logic [BA_W-1:0]  ba;
        logic [ADDR_W-1:0] addr;
        int               gap;
        string            req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pwr_stable = 1'b0;
    logic [ADDR_W-1:0] mr_cfg = '0;
    logic [ADDR_W-1:0] emr_cfg = '0;
    logic              cke, dqm, cs_n, ras_n, cas_n, we_n;
    logic [BA_W-1:0]   ba;
    logic [ADDR_W-1:0] addr;
    logic              init_done, cfg_err;

    int   checks = 0;
    int   errors = 0;
    int   nop_cnt = 0;
    bit   prev_done = 0;
    bit   prev_err = 0;
    int   exp_err_gap = -1;
    exp_t q[$];

    always #4 clk = ~clk;

    sdram_pwrup_seq #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .T_STABLE(T_STABLE),
        .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD)
    ) u_sdram_pwrup_seq (
        .clk(clk), .rst_n(rst_n), .pwr_stable(pwr_stable),
        .mr_cfg(mr_cfg), .emr_cfg(emr_cfg),
        .cke(cke), .dqm(dqm), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr),
        .init_done(init_done), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int decode();
        if (cs_n) return 0;
        case ({ras_n, cas_n, we_n})
            3'b111:  return 0;
            3'b010:  return 1;
            3'b001:  return 2;
            3'b000:  return 3;
            default: return 9;
        endcase
    endfunction

    // monitor: samples pins at the falling edge and pops the scoreboard
    always @(negedge clk) begin
        check(cke && dqm, "R1", {cke, dqm}, 3);
        if (!rst_n) begin
            nop_cnt   = 0;
            prev_done = 0;
            prev_err  = 0;
        end else begin
            int code;
            code = decode();
            if (prev_done && !init_done) check(0, "R8", 0, 1);
            if (init_done && !prev_done) check(nop_cnt == T_MRD, "R8", nop_cnt, T_MRD);
            if (cfg_err && !prev_err) check(nop_cnt == exp_err_gap, "R7", nop_cnt, exp_err_gap);
            if (code != 0) begin
                if (q.size() == 0) begin
                    check(0, "R2", code, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(code == e.code, e.req, code, e.code);
                    check(nop_cnt == e.gap, e.req, nop_cnt, e.gap);
                    if (e.code == 1) check(addr[10] == 1'b1, "R3", addr[10], 1);
                    if (e.code == 3) begin
                        check(ba == e.ba, e.req, ba, e.ba);
                        check(addr == e.addr, e.req, addr, e.addr);
                    end
                end
                nop_cnt = 0;
            end else begin
                nop_cnt++;
            end
            prev_done = init_done;
            prev_err  = cfg_err;
        end
    end

    task automatic push(input int code, input logic [BA_W-1:0] b,
                        input logic [ADDR_W-1:0] a, input int gap, input string req);
        exp_t e;
        e.code = code; e.ba = b; e.addr = a; e.gap = gap; e.req = req;
        q.push_back(e);
    endtask

    task automatic push_front_part();
        push(1, '0, '0, T_STABLE, "R3");
        push(2, '0, '0, T_RP, "R4");
        push(2, '0, '0, T_RFC, "R5");
    endtask

    task automatic push_full(input logic [ADDR_W-1:0] mr, input logic [ADDR_W-1:0] emr);
        push_front_part();
        push(3, 2'b00, mr, T_RFC, "R6");
        push(3, 2'b10, emr, T_MRD, "R6");
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk); #1;
        rst_n = 1'b0;
        pwr_stable = 1'b0;
        repeat (cycles) @(negedge clk);
        check(!init_done && !cfg_err, "R9", {init_done, cfg_err}, 0);
        check(decode() == 0 && !cs_n, "R9", decode(), 0);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic power_up();
        @(negedge clk); #1;
        pwr_stable = 1'b1;
        nop_cnt = 0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!init_done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(init_done, "R8", init_done, 1);
        repeat (15) @(negedge clk);
        check(init_done, "R8", init_done, 1);
        check(q.size() == 0, "R6", q.size(), 0);
    endtask

    task automatic bad_cl_case(input logic [ADDR_W-1:0] mr);
        do_reset(3);
        mr_cfg = mr;
        emr_cfg = 13'h0040;
        exp_err_gap = T_RFC + 1;
        push_front_part();
        power_up();
        for (int n = 0; n < 3000 && !cfg_err; n++) @(negedge clk);
        check(cfg_err, "R7", cfg_err, 1);
        repeat (20) @(negedge clk);
        check(!init_done && cfg_err, "R7", init_done, 0);
        check(q.size() == 0, "R7", q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // reset state
        repeat (3) @(negedge clk);
        check(!init_done && !cfg_err, "R9", {init_done, cfg_err}, 0);
        check(cke && dqm, "R1", {cke, dqm}, 3);
        check(!cs_n && ras_n && cas_n && we_n, "R2", {cs_n, ras_n, cas_n, we_n}, 7);
        #1;
        rst_n = 1'b1;

        // power not yet good: only idle commands (monitor fails any command)
        repeat (30) @(negedge clk);
        check(q.size() == 0 && !init_done, "R2", init_done, 0);

        // full sequence, CAS latency 3, single-write mode, burst length 4
        mr_cfg  = 13'h0232;
        emr_cfg = 13'h0020;
        push_full(mr_cfg, emr_cfg);
        power_up();
        wait_done();

        // reset in the middle of refresh phase, then restart (R9)
        do_reset(2);
        mr_cfg  = 13'h0023;
        emr_cfg = 13'h0007;
        repeat (10) @(negedge clk);
        push_full(mr_cfg, emr_cfg);
        power_up();
        for (int n = 0; n < 3000 && q.size() > 3; n++) @(negedge clk);
        repeat (2) @(negedge clk);
        check(q.size() == 3, "R9", q.size(), 3);
        q.delete();
        do_reset(4);
        repeat (5) @(negedge clk);
        check(!init_done, "R9", init_done, 0);
        push_full(mr_cfg, emr_cfg);
        power_up();
        wait_done();

        // illegal CAS-latency codes (R7)
        bad_cl_case(13'h0052);
        bad_cl_case(13'h0003);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule